// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps the mode-related bits of a two-level processor's condition code: the interrupt-enable bit (set means the core runs user code), the sleep bit, the break-enable bit, a single-step bit, the trap bit and a floating-point-enable position that is wired to zero. The core feeds it decoded events each cycle: writes to the user or supervisor condition code, an executed break instruction, an external interrupt line and a resume request from the debug side. The block answers with the current mode, a halt request, a one-cycle pulse when control passes to the supervisor, and both condition-code views.

The control is a four-state machine. SUPER is supervisor execution, USER is user execution, DOZE is a user-mode sleep waiting for an interrupt, and STOPPED is a halt that only a resume leaves. Transitions: SUPER to USER (supervisor write with enable set, sleep clear), SUPER to DOZE (supervisor write with enable and sleep set), SUPER to STOPPED (break, or supervisor write with sleep set and enable clear), USER to SUPER (interrupt, unguarded break, or user write clearing enable), USER to STOPPED (break with break-enable set), USER to DOZE (user write keeping enable and setting sleep), DOZE to SUPER (interrupt), STOPPED to SUPER (resume). The trap bit tells the supervisor whether its last entry was caused by user software (1) or by a hardware interrupt (0).

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset the block is in SUPER: user_mode=0, halt_req=0, enter_sup=0 and both condition-code views read all zeros.
- R2: In USER, a user condition-code write with bit 5 (enable) clear, with no interrupt or break that cycle, moves to SUPER after one clock, sets trap (bit 9) and pulses enter_sup for exactly one cycle.
- R3: In SUPER, a supervisor condition-code write with bit 5 set and no break moves to user mode (USER, or DOZE if bit 4 is also set) and clears trap.
- R4: A break executed in SUPER moves to STOPPED (halt_req=1) on the next cycle.
- R5: A break in USER halts when break-enable (bit 7) is 1; when it is 0 the block enters SUPER with trap=1 and an enter_sup pulse.
- R6: Bit 8 of both condition-code views always reads 0.
- R7: A user write that clears bit 5 and sets bit 4 in one cycle enters SUPER with sleep (bit 4) at 0 and no halt.
- R8: An interrupt in USER or DOZE enters SUPER with trap=0 and an enter_sup pulse; an interrupt in SUPER or STOPPED changes nothing.
- R9: DOZE reports user_mode=1 and sleep bit 4 set; a supervisor write with bit 4 set and bit 5 clear halts.
- R10: STOPPED is left only through resume, into SUPER; writes, breaks and interrupts there change nothing.
- R11: Bits 3:0 are per mode: a user-CC write updates the user view's flags; a supervisor-CC write in SUPER updates the supervisor flags, step (bit 6) and break-enable (bit 7); user code cannot change bits 6 and 7.
- R12: In USER an interrupt takes priority over a break, and a break over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_cc_we | input | 1 | Write to the user condition code this cycle |
| sup_cc_we | input | 1 | Write to the supervisor condition code this cycle |
| cc_wdata | input | 10 | Condition-code write data |
| brk_exec | input | 1 | Break instruction executed this cycle |
| irq_in | input | 1 | External interrupt request |
| resume | input | 1 | Release from STOPPED |
| user_mode | output | 1 | Interrupt enable, i.e. user mode (USER or DOZE) |
| halt_req | output | 1 | Core must halt (STOPPED) |
| enter_sup | output | 1 | One-cycle pulse after a switch into SUPER from user mode |
| cc_usr | output | 10 | User condition-code view |
| cc_sup | output | 10 | Supervisor condition-code view |

## Verification
The hardest situation to reach is the single user write that both drops enable and sets sleep, because it needs the block already in USER with no interrupt or break in the same cycle; the bench first lets the supervisor enable user mode, then issues that write alone and checks sleep and halt stay low. Priority between simultaneous interrupt, break and write in USER is reached the same way, followed by a long stretch of biased random events that a behavioural model follows cycle by cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int FLAG_W   = 4;
    localparam int CC_SLEEP = FLAG_W;
    localparam int CC_GIE   = FLAG_W + 1;
    localparam int CC_STEP  = FLAG_W + 2;
    localparam int CC_BRKEN = FLAG_W + 3;
    localparam int CC_FPEN  = FLAG_W + 4;
    localparam int CC_TRAP  = FLAG_W + 5;
    localparam int CC_W     = FLAG_W + 6;

    typedef enum logic [1:0] {
        ST_SUPER   = 2'd0,
        ST_USER    = 2'd1,
        ST_DOZE    = 2'd2,
        ST_STOPPED = 2'd3
    } pmc_state_t;

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_HW      = 2'd1,
        EV_SW      = 2'd2,
        EV_TO_USER = 2'd3
    } pmc_event_t;
endpackage

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            usr_we,
    input  logic            sup_we,
    input  logic [CC_W-1:0] wdata,
    input  logic            brk,
    input  logic            irq,
    input  logic            resume,
    input  logic            brk_en,
    output pmc_state_t      state,
    output pmc_event_t      evt,
    output logic            usr_flag_we,
    output logic            sup_cfg_we,
    output logic            enter_sup
);
    pmc_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_SUPER;
            enter_sup <= 1'b0;
        end else begin
            st_q      <= st_d;
            enter_sup <= (evt == EV_HW) || (evt == EV_SW);
        end
    end

    always_comb begin
        st_d        = st_q;
        evt         = EV_NONE;
        usr_flag_we = 1'b0;
        sup_cfg_we  = 1'b0;
        unique case (st_q)
            ST_SUPER: begin
                if (brk) begin
                    st_d = ST_STOPPED;
                end else begin
                    usr_flag_we = usr_we;
                    sup_cfg_we  = sup_we;
                    if (sup_we) begin
                        if (wdata[CC_GIE]) begin
                            evt  = EV_TO_USER;
                            st_d = wdata[CC_SLEEP] ? ST_DOZE : ST_USER;
                        end else if (wdata[CC_SLEEP]) begin
                            st_d = ST_STOPPED;
                        end
                    end
                end
            end
            ST_USER: begin
                if (irq) begin
                    evt  = EV_HW;
                    st_d = ST_SUPER;
                end else if (brk) begin
                    if (brk_en) begin
                        st_d = ST_STOPPED;
                    end else begin
                        evt  = EV_SW;
                        st_d = ST_SUPER;
                    end
                end else if (usr_we) begin
                    usr_flag_we = 1'b1;
                    if (!wdata[CC_GIE]) begin
                        evt  = EV_SW;
                        st_d = ST_SUPER;
                    end else if (wdata[CC_SLEEP]) begin
                        st_d = ST_DOZE;
                    end
                end
            end
            ST_DOZE: begin
                if (irq) begin
                    evt  = EV_HW;
                    st_d = ST_SUPER;
                end
            end
            ST_STOPPED: begin
                if (resume) st_d = ST_SUPER;
            end
            default: st_d = ST_SUPER;
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/pmc_ccbits.sv
module pmc_ccbits
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CC_W-1:0]   wdata,
    input  logic              usr_flag_we,
    input  logic              sup_cfg_we,
    input  pmc_event_t        evt,
    output logic [FLAG_W-1:0] flags_usr,
    output logic [FLAG_W-1:0] flags_sup,
    output logic              brk_en,
    output logic              step,
    output logic              trap
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_usr <= '0;
            flags_sup <= '0;
            brk_en    <= 1'b0;
            step      <= 1'b0;
        end else begin
            if (usr_flag_we) flags_usr <= wdata[FLAG_W-1:0];
            if (sup_cfg_we) begin
                flags_sup <= wdata[FLAG_W-1:0];
                brk_en    <= wdata[CC_BRKEN];
                step      <= wdata[CC_STEP];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap <= 1'b0;
        end else begin
            unique case (evt)
                EV_SW:      trap <= 1'b1;
                EV_HW:      trap <= 1'b0;
                EV_TO_USER: trap <= 1'b0;
                default:    trap <= trap;
            endcase
        end
    end
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
    import pmc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            usr_cc_we,
    input  logic            sup_cc_we,
    input  logic [CC_W-1:0] cc_wdata,
    input  logic            brk_exec,
    input  logic            irq_in,
    input  logic            resume,
    output logic            user_mode,
    output logic            halt_req,
    output logic            enter_sup,
    output logic [CC_W-1:0] cc_usr,
    output logic [CC_W-1:0] cc_sup
);
    pmc_state_t        state;
    pmc_event_t        evt;
    logic              usr_flag_we, sup_cfg_we;
    logic [FLAG_W-1:0] flags_usr, flags_sup;
    logic              brk_en, step, trap;
    logic [CC_W-1:FLAG_W] mode_bits;

    pmc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .usr_we      (usr_cc_we),
        .sup_we      (sup_cc_we),
        .wdata       (cc_wdata),
        .brk         (brk_exec),
        .irq         (irq_in),
        .resume      (resume),
        .brk_en      (brk_en),
        .state       (state),
        .evt         (evt),
        .usr_flag_we (usr_flag_we),
        .sup_cfg_we  (sup_cfg_we),
        .enter_sup   (enter_sup)
    );

    pmc_ccbits u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .wdata       (cc_wdata),
        .usr_flag_we (usr_flag_we),
        .sup_cfg_we  (sup_cfg_we),
        .evt         (evt),
        .flags_usr   (flags_usr),
        .flags_sup   (flags_sup),
        .brk_en      (brk_en),
        .step        (step),
        .trap        (trap)
    );

    always_comb begin
        user_mode = (state == ST_USER) || (state == ST_DOZE);
        halt_req  = (state == ST_STOPPED);
        mode_bits[CC_SLEEP] = (state == ST_DOZE);
        mode_bits[CC_GIE]   = user_mode;
        mode_bits[CC_STEP]  = step;
        mode_bits[CC_BRKEN] = brk_en;
        mode_bits[CC_FPEN]  = 1'b0;
        mode_bits[CC_TRAP]  = trap;
    end

    assign cc_usr = {mode_bits, flags_usr};
    assign cc_sup = {mode_bits, flags_sup};
endmodule

// File: rtl/priv_mode_ctrl_chk.sv
module priv_mode_ctrl_chk
    import pmc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            usr_cc_we,
    input logic            sup_cc_we,
    input logic [CC_W-1:0] cc_wdata,
    input logic            brk_exec,
    input logic            irq_in,
    input logic            resume,
    input logic            user_mode,
    input logic            halt_req,
    input logic            enter_sup,
    input logic [CC_W-1:0] cc_usr,
    input logic [CC_W-1:0] cc_sup
);
    logic in_user;
    assign in_user = user_mode && !cc_sup[CC_SLEEP];

    p_user_drop_trap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_user && usr_cc_we && !cc_wdata[CC_GIE] && !irq_in && !brk_exec
        |=> !user_mode && cc_sup[CC_TRAP] && enter_sup);

    p_sup_resume_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode && !halt_req && sup_cc_we && cc_wdata[CC_GIE] && !brk_exec
        |=> user_mode && !cc_sup[CC_TRAP]);

    p_sup_break_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode && !halt_req && brk_exec |=> halt_req);

    p_fp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_usr[CC_FPEN] && !cc_sup[CC_FPEN]);

    p_no_sleep_on_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_user && usr_cc_we && !cc_wdata[CC_GIE] && cc_wdata[CC_SLEEP] && !irq_in && !brk_exec
        |=> !cc_sup[CC_SLEEP] && !halt_req);

    p_hw_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode && irq_in |=> !user_mode && !cc_sup[CC_TRAP] && enter_sup);

    p_pulse_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        enter_sup |-> $past(user_mode) && !user_mode);

    p_halt_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req && !resume |=> halt_req);
endmodule

bind priv_mode_ctrl priv_mode_ctrl_chk u_chk (.*);

// File: tb/tb_priv_mode_ctrl.sv
module tb_priv_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usr_cc_we = 0, sup_cc_we = 0, brk_exec = 0, irq_in = 0, resume = 0;
    logic [9:0] cc_wdata = '0;
    logic       user_mode, halt_req, enter_sup;
    logic [9:0] cc_usr, cc_sup;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state: 0 super, 1 user, 2 doze, 3 stopped
    int         m_mode;
    bit         m_trap, m_brk, m_step, m_pulse;
    logic [3:0] m_fu, m_fs;

    always #10 clk = ~clk;

    priv_mode_ctrl dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] m_cc(logic [3:0] f);
        bit gie, slp;
        gie = (m_mode == 1) || (m_mode == 2);
        slp = (m_mode == 2);
        return {m_trap, 1'b0, m_brk, m_step, gie, slp, f};
    endfunction

    task automatic m_reset();
        m_mode = 0; m_trap = 0; m_brk = 0; m_step = 0; m_pulse = 0; m_fu = 0; m_fs = 0;
    endtask

    task automatic m_step_clk();
        m_pulse = 0;
        case (m_mode)
            0: begin
                if (brk_exec) m_mode = 3;
                else begin
                    if (usr_cc_we) m_fu = cc_wdata[3:0];
                    if (sup_cc_we) begin
                        m_fs = cc_wdata[3:0]; m_brk = cc_wdata[7]; m_step = cc_wdata[6];
                        if (cc_wdata[5]) begin m_trap = 0; m_mode = cc_wdata[4] ? 2 : 1; end
                        else if (cc_wdata[4]) m_mode = 3;
                    end
                end
            end
            1: begin
                if (irq_in) begin m_mode = 0; m_trap = 0; m_pulse = 1; end
                else if (brk_exec) begin
                    if (m_brk) m_mode = 3;
                    else begin m_mode = 0; m_trap = 1; m_pulse = 1; end
                end else if (usr_cc_we) begin
                    m_fu = cc_wdata[3:0];
                    if (!cc_wdata[5]) begin m_mode = 0; m_trap = 1; m_pulse = 1; end
                    else if (cc_wdata[4]) m_mode = 2;
                end
            end
            2: if (irq_in) begin m_mode = 0; m_trap = 0; m_pulse = 1; end
            default: if (resume) m_mode = 0;
        endcase
    endtask

    task automatic compare(string tag);
        chk({tag, " R2 R3 mode"}, user_mode, (m_mode == 1) || (m_mode == 2));
        chk({tag, " R4 R10 halt"}, halt_req, m_mode == 3);
        chk({tag, " R8 enter_sup"}, enter_sup, m_pulse);
        chk({tag, " R11 cc_usr"}, cc_usr, m_cc(m_fu));
        chk({tag, " R11 cc_sup"}, cc_sup, m_cc(m_fs));
        chk({tag, " R6 fp bit"}, {cc_usr[8], cc_sup[8]}, 2'b00);
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(string tag, bit uw, bit sw, logic [9:0] d, bit b, bit i, bit r);
        usr_cc_we = uw; sup_cc_we = sw; cc_wdata = d; brk_exec = b; irq_in = i; resume = r;
        @(posedge clk);
        m_step_clk();
        @(negedge clk);
        usr_cc_we = 0; sup_cc_we = 0; brk_exec = 0; irq_in = 0; resume = 0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset mode", {user_mode, halt_req, enter_sup}, 3'b000);
        chk("R1 reset cc", {cc_usr, cc_sup}, 20'h0);

        cyc("R3", 0, 1, 10'h023, 0, 0, 0);
        chk("R3 user entered, trap clear", {user_mode, cc_sup[9], cc_sup[3:0]}, 6'b1_0_0011);
        cyc("R11", 1, 0, 10'h0EF, 0, 0, 0);
        chk("R11 user flags, no brk/step", {cc_usr[7:6], cc_usr[3:0]}, 6'b00_1111);
        cyc("R7", 1, 0, 10'h010, 0, 0, 0);
        chk("R7 R2 drop without sleep", {user_mode, cc_sup[4], halt_req, cc_sup[9], enter_sup}, 5'b0_0_0_1_1);
        cyc("R2", 0, 0, 10'h000, 0, 0, 0);
        chk("R2 pulse one cycle", enter_sup, 1'b0);
        cyc("R8", 0, 0, 10'h000, 0, 1, 0);
        chk("R8 irq in super ignored", {user_mode, enter_sup}, 2'b00);
        cyc("R4", 0, 0, 10'h000, 1, 0, 0);
        chk("R4 super break halts", halt_req, 1'b1);
        cyc("R10", 1, 1, 10'h020, 1, 1, 0);
        chk("R10 stopped ignores events", {halt_req, user_mode}, 2'b10);
        cyc("R10", 0, 0, 10'h000, 0, 0, 1);
        chk("R10 resume to super", {halt_req, user_mode}, 2'b00);
        cyc("R5", 0, 1, 10'h0A0, 0, 0, 0);
        cyc("R5", 0, 0, 10'h000, 1, 0, 0);
        chk("R5 guarded break halts", halt_req, 1'b1);
        cyc("R5", 0, 0, 10'h000, 0, 0, 1);
        cyc("R5", 0, 1, 10'h020, 0, 0, 0);
        cyc("R5", 0, 0, 10'h000, 1, 0, 0);
        chk("R5 unguarded break traps", {user_mode, cc_sup[9], enter_sup}, 3'b011);
        cyc("R8", 0, 1, 10'h020, 0, 0, 0);
        cyc("R8", 0, 0, 10'h000, 0, 1, 0);
        chk("R8 hw irq clears trap", {user_mode, cc_sup[9], enter_sup}, 3'b001);
        cyc("R9", 0, 1, 10'h030, 0, 0, 0);
        chk("R9 doze", {user_mode, cc_sup[4], halt_req}, 3'b110);
        cyc("R9", 0, 0, 10'h000, 0, 1, 0);
        chk("R9 irq wakes to super", {user_mode, cc_sup[4], enter_sup}, 3'b001);
        cyc("R9", 0, 1, 10'h010, 0, 0, 0);
        chk("R9 sleep without enable halts", halt_req, 1'b1);
        cyc("R12", 0, 0, 10'h000, 0, 0, 1);
        cyc("R12", 0, 1, 10'h0A0, 0, 0, 0);
        cyc("R12", 1, 0, 10'h000, 1, 1, 0);
        chk("R12 irq beats break", {user_mode, halt_req, cc_sup[9]}, 3'b000);
        cyc("R12", 0, 1, 10'h020, 0, 0, 0);
        cyc("R12", 1, 0, 10'h0A0, 1, 0, 0);
        chk("R12 break beats write", {user_mode, cc_sup[9], cc_usr[3:0]}, 6'b0_1_0000);

        for (int n = 0; n < 4000; n++) begin
            cyc("rand", ($urandom % 4) == 0, ($urandom % 4) == 0, 10'($urandom),
                ($urandom % 12) == 0, ($urandom % 10) == 0, ($urandom % 3) == 0);
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule